// File: doc/BRIEF.md
# Instruction Decoder and Control Unit

This block takes one 16-bit instruction word and produces, in the same cycle and with no state, every control signal that a single-cycle 16-bit load-store datapath needs. The instruction set has three formats and a 4-bit opcode. Opcode 0000 selects register-to-register work, and a 3-bit function field picks the operation, including the indirect jump through a register. The other fourteen defined opcodes each name one immediate, memory, branch or jump instruction.

The decoder splits the word into its fields: the opcode, the three register numbers, the function code, and the short and long immediates. It also drives the short immediate sign-extended to 16 bits. The control outputs choose whether and where the register file is written, which ALU operand and ALU operation to use, whether data memory is written or read back into a register, and how the program counter is redirected. The register file, ALU, memories and program counter live outside this block. They use these outputs unchanged.

Top module: `insn_ctrl_decode`

## Requirements
- R1: The fields are taken from fixed bit positions: op = instr[15:12], rs = instr[11:9], rt = instr[8:6], rd = instr[5:3], fn = instr[2:0], imm6 = instr[5:0], imm12 = instr[11:0]. This holds for every instruction word.
- R2: imm_ext is imm6 sign-extended to 16 bits, for every word. Bits 15..6 all copy instr[5].
- R3: With op 0000 and fn 000..110, reg_wr=1, dst_sel=00 (rd), alu_src=0 and alu_op = {0,fn}. The ALU codes are OR=0, AND=1, NOR=2, XOR=3, ADD=4, SUB=5, SLT=6, SLL=7, SRL=8, SRA=9. All other controls are 0.
- R4: With op 0000 and fn 111, jr=1 and alu_op=ADD. Every other control is 0, whatever the values of rt and rd.
- R5: Immediate ALU opcodes set reg_wr=1, dst_sel=01 (rt) and alu_src=1, and all other controls are 0. The opcodes and their ALU codes are: 1000 OR, 1001 AND, 1010 SLL, 1011 SRL, 1100 ADD, 1101 SUB, 1110 SLT, 0001 SRA.
- R6: Load (0010) sets reg_wr=1, dst_sel=01, alu_src=1, alu_op=ADD and mem_to_reg=1. Store (0011) sets mem_wr=1, alu_src=1 and alu_op=ADD, with no register write.
- R7: Branch-equal (0100) sets br_eq=1 and branch-not-equal (0101) sets br_ne=1. Both use alu_src=0 and alu_op=SUB, and write nothing.
- R8: Jump (0110) sets jmp=1. Jump-and-link (0111) sets jmp=1, jal=1, reg_wr=1 and dst_sel=10 (register 7). Both use alu_op=ADD.
- R9: Opcode 1111 is a no-op. All controls are 0 except alu_op=ADD.
- R10: For any word, at most one of br_eq, br_ne, jmp and jr is set. reg_wr and mem_wr are never set together. mem_to_reg is only set with reg_wr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 16 | Instruction word |
| op | output | 4 | Opcode field |
| rs | output | 3 | First source register number |
| rt | output | 3 | Second source or immediate destination register number |
| rd | output | 3 | Register-format destination register number |
| fn | output | 3 | Function field |
| imm6 | output | 6 | Short immediate |
| imm12 | output | 12 | Long jump immediate |
| imm_ext | output | 16 | Sign-extended short immediate |
| reg_wr | output | 1 | Register file write enable |
| dst_sel | output | 2 | Destination select: 00 rd, 01 rt, 10 register 7 |
| alu_src | output | 1 | ALU second operand: 0 register, 1 imm_ext |
| alu_op | output | 4 | ALU operation code |
| mem_wr | output | 1 | Data memory write enable |
| mem_to_reg | output | 1 | Write-back data from memory instead of ALU |
| br_eq | output | 1 | Branch taken when operands are equal |
| br_ne | output | 1 | Branch taken when operands differ |
| jmp | output | 1 | Pseudo-direct jump |
| jal | output | 1 | Jump writes return address to register 7 |
| jr | output | 1 | Jump to the address held in rs |

## Verification
The block holds no state, so a wrong decode shows at the ports in the same cycle as the word that causes it and disappears with the next word. Because of this, every one of the 128 opcode and function combinations is driven and the whole control vector is compared for each one. A wrong case arm shows as a wrong write enable, destination or ALU code on exactly the words that reach it. Exclusivity rules, such as a single PC redirect, are also checked continuously, so a decode that drives two of them at once is caught on the word that does it.

// File: rtl/icd_pkg.sv
package icd_pkg;
  localparam int unsigned WORD_W  = 16;
  localparam int unsigned OP_W    = 4;
  localparam int unsigned REG_W   = 3;
  localparam int unsigned FN_W    = 3;
  localparam int unsigned IMM_S_W = 6;
  localparam int unsigned IMM_L_W = 12;
  localparam int unsigned ALU_W   = 4;
  localparam int unsigned DST_W   = 2;

  typedef enum logic [ALU_W-1:0] {
    ALU_OR  = 4'd0, ALU_AND = 4'd1, ALU_NOR = 4'd2, ALU_XOR = 4'd3,
    ALU_ADD = 4'd4, ALU_SUB = 4'd5, ALU_SLT = 4'd6, ALU_SLL = 4'd7,
    ALU_SRL = 4'd8, ALU_SRA = 4'd9
  } alu_op_e;

  typedef enum logic [DST_W-1:0] {
    DST_RD = 2'd0, DST_RT = 2'd1, DST_LINK = 2'd2
  } dst_sel_e;

  typedef enum logic [OP_W-1:0] {
    OP_REG  = 4'd0,  OP_SRAI = 4'd1,  OP_LOAD = 4'd2,  OP_STORE = 4'd3,
    OP_BEQ  = 4'd4,  OP_BNE  = 4'd5,  OP_JMP  = 4'd6,  OP_JLINK = 4'd7,
    OP_ORI  = 4'd8,  OP_ANDI = 4'd9,  OP_SLLI = 4'd10, OP_SRLI  = 4'd11,
    OP_ADDI = 4'd12, OP_SUBI = 4'd13, OP_SLTI = 4'd14, OP_NONE  = 4'd15
  } opcode_e;

  localparam logic [FN_W-1:0] FN_JREG = 3'b111;

  typedef struct packed {
    logic     reg_wr;
    dst_sel_e dst_sel;
    logic     alu_src;
    logic     mem_wr;
    logic     mem_to_reg;
    logic     br_eq;
    logic     br_ne;
    logic     jmp;
    logic     jal;
    logic     jr;
  } ctl_t;
endpackage

// File: rtl/icd_fields.sv
module icd_fields #(
  parameter int unsigned WORD_W  = 16,
  parameter int unsigned OP_W    = 4,
  parameter int unsigned REG_W   = 3,
  parameter int unsigned FN_W    = 3,
  parameter int unsigned IMM_S_W = 6,
  parameter int unsigned IMM_L_W = 12
) (
  input  logic [WORD_W-1:0]  word,
  output logic [OP_W-1:0]    op,
  output logic [REG_W-1:0]   rs,
  output logic [REG_W-1:0]   rt,
  output logic [REG_W-1:0]   rd,
  output logic [FN_W-1:0]    fn,
  output logic [IMM_S_W-1:0] imm_s,
  output logic [IMM_L_W-1:0] imm_l,
  output logic [WORD_W-1:0]  imm_sx
);
  localparam int unsigned RS_LO  = WORD_W - OP_W - REG_W;
  localparam int unsigned RT_LO  = RS_LO - REG_W;
  localparam int unsigned RD_LO  = RT_LO - REG_W;
  localparam int unsigned EXT_W  = WORD_W - IMM_S_W;

  assign op     = word[WORD_W-1 -: OP_W];
  assign rs     = word[RS_LO +: REG_W];
  assign rt     = word[RT_LO +: REG_W];
  assign rd     = word[RD_LO +: REG_W];
  assign fn     = word[FN_W-1:0];
  assign imm_s  = word[IMM_S_W-1:0];
  assign imm_l  = word[IMM_L_W-1:0];
  assign imm_sx = {{EXT_W{imm_s[IMM_S_W-1]}}, imm_s};
endmodule

// File: rtl/icd_main.sv
module icd_main
  import icd_pkg::*;
(
  input  logic [OP_W-1:0] op,
  input  logic [FN_W-1:0] fn,
  output ctl_t            ctl
);
  opcode_e opc;
  assign opc = opcode_e'(op);

  always_comb begin
    ctl = '0;
    unique case (opc)
      OP_REG: begin
        if (fn == FN_JREG) begin
          ctl.jr = 1'b1;
        end else begin
          ctl.reg_wr  = 1'b1;
          ctl.dst_sel = DST_RD;
        end
      end
      OP_ORI, OP_ANDI, OP_SLLI, OP_SRLI,
      OP_ADDI, OP_SUBI, OP_SLTI, OP_SRAI: begin
        ctl.reg_wr  = 1'b1;
        ctl.dst_sel = DST_RT;
        ctl.alu_src = 1'b1;
      end
      OP_LOAD: begin
        ctl.reg_wr     = 1'b1;
        ctl.dst_sel    = DST_RT;
        ctl.alu_src    = 1'b1;
        ctl.mem_to_reg = 1'b1;
      end
      OP_STORE: begin
        ctl.mem_wr  = 1'b1;
        ctl.alu_src = 1'b1;
      end
      OP_BEQ:   ctl.br_eq = 1'b1;
      OP_BNE:   ctl.br_ne = 1'b1;
      OP_JMP:   ctl.jmp   = 1'b1;
      OP_JLINK: begin
        ctl.jmp     = 1'b1;
        ctl.jal     = 1'b1;
        ctl.reg_wr  = 1'b1;
        ctl.dst_sel = DST_LINK;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/icd_alu_sel.sv
module icd_alu_sel
  import icd_pkg::*;
(
  input  logic [OP_W-1:0] op,
  input  logic [FN_W-1:0] fn,
  output alu_op_e         alu_op
);
  opcode_e opc;
  assign opc = opcode_e'(op);

  always_comb begin
    alu_op = ALU_ADD;
    case (opc)
      OP_REG:           alu_op = (fn == FN_JREG) ? ALU_ADD : alu_op_e'({1'b0, fn});
      OP_ORI:           alu_op = ALU_OR;
      OP_ANDI:          alu_op = ALU_AND;
      OP_SLLI:          alu_op = ALU_SLL;
      OP_SRLI:          alu_op = ALU_SRL;
      OP_SRAI:          alu_op = ALU_SRA;
      OP_ADDI:          alu_op = ALU_ADD;
      OP_SUBI:          alu_op = ALU_SUB;
      OP_SLTI:          alu_op = ALU_SLT;
      OP_BEQ, OP_BNE:   alu_op = ALU_SUB;
      default:          alu_op = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/insn_ctrl_decode.sv
module insn_ctrl_decode
  import icd_pkg::*;
(
  input  logic [15:0] instr,
  output logic [3:0]  op,
  output logic [2:0]  rs,
  output logic [2:0]  rt,
  output logic [2:0]  rd,
  output logic [2:0]  fn,
  output logic [5:0]  imm6,
  output logic [11:0] imm12,
  output logic [15:0] imm_ext,
  output logic        reg_wr,
  output logic [1:0]  dst_sel,
  output logic        alu_src,
  output logic [3:0]  alu_op,
  output logic        mem_wr,
  output logic        mem_to_reg,
  output logic        br_eq,
  output logic        br_ne,
  output logic        jmp,
  output logic        jal,
  output logic        jr
);
  ctl_t    ctl;
  alu_op_e alu_code;

  icd_fields #(
    .WORD_W(WORD_W), .OP_W(OP_W), .REG_W(REG_W), .FN_W(FN_W),
    .IMM_S_W(IMM_S_W), .IMM_L_W(IMM_L_W)
  ) u_fields (
    .word(instr), .op(op), .rs(rs), .rt(rt), .rd(rd), .fn(fn),
    .imm_s(imm6), .imm_l(imm12), .imm_sx(imm_ext)
  );

  icd_main u_main (.op(op), .fn(fn), .ctl(ctl));

  icd_alu_sel u_alu (.op(op), .fn(fn), .alu_op(alu_code));

  assign reg_wr     = ctl.reg_wr;
  assign dst_sel    = ctl.dst_sel;
  assign alu_src    = ctl.alu_src;
  assign alu_op     = alu_code;
  assign mem_wr     = ctl.mem_wr;
  assign mem_to_reg = ctl.mem_to_reg;
  assign br_eq      = ctl.br_eq;
  assign br_ne      = ctl.br_ne;
  assign jmp        = ctl.jmp;
  assign jal        = ctl.jal;
  assign jr         = ctl.jr;
endmodule

// File: rtl/icd_checker.sv
module icd_checker (
  input logic [5:0]  imm6,
  input logic [15:0] imm_ext,
  input logic        reg_wr,
  input logic [1:0]  dst_sel,
  input logic        alu_src,
  input logic [3:0]  alu_op,
  input logic        mem_wr,
  input logic        mem_to_reg,
  input logic        br_eq,
  input logic        br_ne,
  input logic        jmp,
  input logic        jal,
  input logic        jr
);
  always_comb begin
    // R2: upper bits uniform and equal to the immediate's sign
    a_r2_sign_ext: assert ((imm_ext[5:0] == imm6) &&
                           (imm_ext[15:6] == '0 || imm_ext[15:6] == '1) &&
                           (imm_ext[6] == imm6[5]))
      else $error("sign extension broken");
    // R10: single PC redirect source
    a_r10_one_redirect: assert ($onehot0({br_eq, br_ne, jmp, jr}))
      else $error("more than one redirect");
    // R10: no register and memory write together
    a_r10_no_dual_write: assert (!(reg_wr && mem_wr))
      else $error("dual write");
    // R10 / R6: load path writes back through an address add
    a_r6_load_path: assert (!mem_to_reg || (reg_wr && alu_src && alu_op == 4'd4))
      else $error("load path inconsistent");
    // R8: link implies jump and write to register 7
    a_r8_link_r7: assert (!jal || (jmp && reg_wr && dst_sel == 2'd2))
      else $error("link inconsistent");
  end
endmodule

bind insn_ctrl_decode icd_checker u_chk (.*);

// File: tb/insn_ctrl_decode_tb.sv
module insn_ctrl_decode_tb;
  typedef struct {
    logic [15:0] word;
    logic [14:0] ctl;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] instr = '0;
  logic [3:0] op; logic [2:0] rs, rt, rd, fn; logic [5:0] imm6;
  logic [11:0] imm12; logic [15:0] imm_ext;
  logic reg_wr, alu_src, mem_wr, mem_to_reg, br_eq, br_ne, jmp, jal, jr;
  logic [1:0] dst_sel; logic [3:0] alu_op;

  int checks = 0;
  int errors = 0;
  exp_t q[$];

  always #2 clk = ~clk;  // 250 MHz

  insn_ctrl_decode u_dut (.*);

  // Reference: {reg_wr, dst_sel, alu_src, alu_op, mem_wr, mem_to_reg, br_eq, br_ne, jmp, jal, jr}
  function automatic logic [14:0] ref_ctl(input logic [15:0] w);
    logic rw = 0, src = 0, mw = 0, m2r = 0, be = 0, bn = 0, j = 0, jl = 0, jrr = 0;
    logic [1:0] dst = 2'd0;
    logic [3:0] alu = 4'd4;
    case (w[15:12])
      4'd0:  if (w[2:0] == 3'd7) jrr = 1; else begin rw = 1; alu = {1'b0, w[2:0]}; end
      4'd8:  begin rw = 1; dst = 1; src = 1; alu = 4'd0; end
      4'd9:  begin rw = 1; dst = 1; src = 1; alu = 4'd1; end
      4'd10: begin rw = 1; dst = 1; src = 1; alu = 4'd7; end
      4'd11: begin rw = 1; dst = 1; src = 1; alu = 4'd8; end
      4'd12: begin rw = 1; dst = 1; src = 1; alu = 4'd4; end
      4'd13: begin rw = 1; dst = 1; src = 1; alu = 4'd5; end
      4'd14: begin rw = 1; dst = 1; src = 1; alu = 4'd6; end
      4'd1:  begin rw = 1; dst = 1; src = 1; alu = 4'd9; end
      4'd2:  begin rw = 1; dst = 1; src = 1; m2r = 1; end
      4'd3:  begin mw = 1; src = 1; end
      4'd4:  begin be = 1; alu = 4'd5; end
      4'd5:  begin bn = 1; alu = 4'd5; end
      4'd6:  j = 1;
      4'd7:  begin j = 1; jl = 1; rw = 1; dst = 2'd2; end
      default: ;
    endcase
    return {rw, dst, src, alu, mw, m2r, be, bn, j, jl, jrr};
  endfunction

  function automatic string ref_tag(input logic [15:0] w);
    case (w[15:12])
      4'd0: return (w[2:0] == 3'd7) ? "R4" : "R3";
      4'd2, 4'd3: return "R6";
      4'd4, 4'd5: return "R7";
      4'd6, 4'd7: return "R8";
      4'd15: return "R9";
      default: return "R5";
    endcase
  endfunction

  task automatic drive(input logic [15:0] w);
    exp_t e;
    @(posedge clk);
    #1;
    instr = w;
    e.word = w; e.ctl = ref_ctl(w); e.tag = ref_tag(w);
    q.push_back(e);
  endtask

  // Monitor: sample at the falling edge, away from the drive point
  always @(negedge clk) begin
    if (rst_n && q.size() > 0) begin
      exp_t e;
      logic [14:0] act;
      logic [37:0] fexp, fact;
      logic [15:0] sx;
      e = q.pop_front();
      act = {reg_wr, dst_sel, alu_src, alu_op, mem_wr, mem_to_reg, br_eq, br_ne, jmp, jal, jr};
      checks++;
      if (act !== e.ctl) begin
        errors++;
        $display("FAIL %s instr=%h ctl act=%b exp=%b", e.tag, e.word, act, e.ctl);
      end
      // R1: field positions
      fexp = {e.word[15:12], e.word[11:9], e.word[8:6], e.word[5:3], e.word[2:0],
              e.word[5:0], e.word[11:0], 4'h0};
      fact = {op, rs, rt, rd, fn, imm6, imm12, 4'h0};
      checks++;
      if (fact !== fexp) begin
        errors++;
        $display("FAIL R1 instr=%h fields act=%h exp=%h", e.word, fact, fexp);
      end
      // R2: sign extension
      sx = e.word[5] ? (16'hFFC0 | {10'h0, e.word[5:0]}) : {10'h0, e.word[5:0]};
      checks++;
      if (imm_ext !== sx) begin
        errors++;
        $display("FAIL R2 instr=%h imm_ext act=%h exp=%h", e.word, imm_ext, sx);
      end
      // R10: exclusivity rules at the ports
      checks++;
      if (!$onehot0({br_eq, br_ne, jmp, jr}) || (reg_wr && mem_wr) || (mem_to_reg && !reg_wr)) begin
        errors++;
        $display("FAIL R10 instr=%h act=%b exp=exclusive", e.word, act);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    instr = 16'h0000;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    drive(16'h0000);                 // reset-state word: OR r0,r0,r0 (R3)
    // Sweep of every opcode and function code (R3..R9)
    for (int o = 0; o < 16; o++) begin
      for (int f = 0; f < 8; f++) begin
        logic [2:0] a, b, c;
        a = 3'(o + 1); b = 3'(f ^ 5); c = 3'(o ^ f);
        drive({4'(o), a, b, c, 3'(f)});
      end
    end
    // R4: jump-register ignores rt and rd bits
    drive(16'h0FFF);
    drive(16'h0E07);
    // R2: immediate boundaries
    drive(16'hC03F);
    drive(16'hC020);
    drive(16'hC01F);
    drive(16'hC000);
    // R9: no-op with all other bits set and clear
    drive(16'hFFFF);
    drive(16'hF000);
    // R8: long immediate patterns
    drive(16'h7ABC);
    drive(16'h6FFF);
    repeat (3) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule